// File: doc/BRIEF.md
# EEPROM Page Write Controller

This block gathers the data bytes of one serial-EEPROM write command into a page-sized staging buffer and then commits them to the storage array in a self-timed programming cycle. A bus target engine, which decodes the serial protocol, tells it when a write command has delivered its word address, hands over each acknowledged data byte, and signals a STOP or a repeated START. The word address is split into a row (page) part and a column part. Bytes land in consecutive columns of the addressed row, and the column wraps inside the page.

When a STOP arrives after at least one stored byte, the controller raises `busy`. It walks the page once, writing into a synchronous RAM that stands in for the array, and touches only the columns that were loaded. It then holds `busy` for a programming time set in system clocks by a parameter. The engine refuses acknowledges while `busy` is high, which gives acknowledge polling. A write-protect input makes the controller drop incoming bytes and refuse to start a programming cycle. A separate read port gives the engine access to the array at all times.

Top module: `ee_page_commit`

## Requirements
- R1: The word address is `{row, column}`: the low `COL_W` (default 4) bits select the column and the upper `ROW_W` (default 7) bits select the row. The first stored byte is written to exactly that array address.
- R2: Each stored byte advances the column by one, and the row does not change. A command may start at any column.
- R3: Past the end of a page the column wraps to 0 in the same row. When more than 16 bytes are sent, a later byte replaces the earlier byte that held the same column.
- R4: Only the columns loaded by the current command are written. All other bytes of the page keep their old values.
- R5: A STOP starts programming only if at least one byte is stored. A STOP that follows only the word address leaves `busy` low and the array unchanged.
- R6: `busy` goes high in the cycle after an accepted STOP and stays high for exactly 16 + `PROG_CYCLES` cycles. While `busy` is high, commands, bytes, STOP and repeated START are ignored.
- R7: While `wp_in` is 1, data bytes are discarded. A STOP seen with `wp_in` at 1 starts no programming: `busy` stays low and the array keeps its contents.
- R8: A repeated START (`restart_evt`) during a write command cancels it. Nothing is committed and `busy` stays low.
- R9: The read port returns `mem[rd_addr]` one clock after `rd_addr` is applied, whatever the level of `wp_in`.
- R10: While `rst_n` is low, and after it is released, `busy` is 0 until a write is committed.
- R11: A new write command clears the record of loaded columns. Bytes taken under an earlier command that had no STOP are not committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_cmd_vld | input | 1 | Write command with word address received (one-cycle pulse) |
| wr_word_addr | input | ROW_W+COL_W | Word address of the write command |
| data_vld | input | 1 | Acknowledged data byte present (one-cycle pulse) |
| data_byte | input | DATA_W | Data byte |
| stop_evt | input | 1 | STOP condition seen on the bus |
| restart_evt | input | 1 | Repeated START seen on the bus |
| wp_in | input | 1 | Write protect, 1 = programming inhibited |
| busy | output | 1 | Programming cycle in progress; engine must not acknowledge |
| rd_addr | input | ROW_W+COL_W | Array read address |
| rd_data | output | DATA_W | Array read data, one cycle after rd_addr |

## Verification
The page write is driven with full pages from column 0 and from a column in mid-page. It is also driven with short runs that cross the page end, a 20-byte run that overlaps itself, a write under protect, and a STOP with no data. Full pages first give three rows a known pattern. A later short write to the same row then shows whether untouched columns survive, which separates partial commit from whole-page commit. The wrapping runs show whether the row is held and the column rolls over. The measured length of `busy`, and whether it appears at all, separates the commit paths from the cancel, protect and empty-STOP paths.

// File: rtl/ee_pgw_pkg.sv
// Shared types of the page write controller.
package ee_pgw_pkg;
    // Controller phases: idle, collecting bytes, walking the page, waiting out programming.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_WAIT   = 2'd3
    } pgw_state_t;
endpackage

// File: rtl/ee_pgw_buffer.sv
// Page staging buffer: one byte per column, a loaded-column mask and a
// wrapping column pointer. Assumes open_cmd, take_byte and drop_all come
// from one controller. open_cmd has priority and take_byte is never raised
// in the same cycle as open_cmd.
module ee_pgw_buffer #(
    parameter int COL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   open_cmd,
    input  logic [COL_W-1:0]       start_col,
    input  logic                   take_byte,
    input  logic [DATA_W-1:0]      byte_in,
    input  logic                   drop_all,
    input  logic [COL_W-1:0]       rd_col,
    output logic [DATA_W-1:0]      rd_byte,
    output logic [(1<<COL_W)-1:0]  mask
);
    localparam int COLS = 1 << COL_W;

    logic [COL_W-1:0]  col_ptr;
    logic [DATA_W-1:0] slot [COLS];

    // Pointer and mask: reload on a new command, clear on cancel, advance per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_ptr <= '0;
            mask    <= '0;
        end else if (open_cmd) begin
            col_ptr <= start_col;
            mask    <= '0;
        end else if (drop_all) begin
            mask    <= '0;
        end else if (take_byte) begin
            mask[col_ptr] <= 1'b1;
            col_ptr       <= col_ptr + 1'b1;
        end
    end

    // One data register per column; a later byte to the same column replaces it.
    for (genvar g = 0; g < COLS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (take_byte && (col_ptr == COL_W'(g)))
                slot[g] <= byte_in;
        end
    end

    // Column read for the commit walker.
    always_comb rd_byte = slot[rd_col];
endmodule

// File: rtl/ee_pgw_timer.sv
// Programming-time counter. A start pulse arms it. done is high in the last
// counted cycle, and running drops after it. Assumes CYCLES >= 1.
module ee_pgw_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic running,
    output logic done
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Count from zero to LAST once per start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= '0;
        end else if (running) begin
            if (cnt == LAST) running <= 1'b0;
            else             cnt     <= cnt + 1'b1;
        end
    end

    // Terminal-count flag.
    always_comb done = running && (cnt == LAST);
endmodule

// File: rtl/ee_pgw_array.sv
// Synchronous RAM standing in for the storage array: one write port and one
// registered read port. A read of the address being written returns the old data.
module ee_pgw_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/ee_page_commit.sv
// Page write controller. It collects the bytes of one write command into the
// staging buffer. On STOP it writes the loaded columns of the addressed row
// into the array, then waits PROG_CYCLES clocks. busy covers both phases.
// Assumes the bus engine gives one-cycle pulses and keeps them apart while
// the bus is idle. PROG_CYCLES >= 1.
module ee_page_commit #(
    parameter int ROW_W       = 7,
    parameter int COL_W       = 4,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 500000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_cmd_vld,
    input  logic [ROW_W+COL_W-1:0]   wr_word_addr,
    input  logic                     data_vld,
    input  logic [DATA_W-1:0]        data_byte,
    input  logic                     stop_evt,
    input  logic                     restart_evt,
    input  logic                     wp_in,
    output logic                     busy,
    input  logic [ROW_W+COL_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]        rd_data
);
    import ee_pgw_pkg::*;

    localparam int ADDR_W = ROW_W + COL_W;
    localparam int COLS   = 1 << COL_W;
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    pgw_state_t       state;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] walk;
    logic [COLS-1:0]  mask;
    logic [DATA_W-1:0] stage_byte;
    logic             in_load, open_cmd, take_byte, drop_all, commit_go;
    logic             tmr_start, tmr_run, tmr_done;
    logic             ram_we;
    logic [ADDR_W-1:0] ram_waddr;

    // Event decoding, priority in LOAD: new command > cancel > STOP > byte.
    always_comb begin
        in_load   = (state == ST_LOAD);
        open_cmd  = ((state == ST_IDLE) || in_load) && wr_cmd_vld;
        drop_all  = in_load && !wr_cmd_vld && restart_evt;
        take_byte = in_load && !wr_cmd_vld && !restart_evt && !stop_evt
                    && data_vld && !wp_in;
        commit_go = in_load && !wr_cmd_vld && !restart_evt && stop_evt
                    && !wp_in && (|mask);
    end

    // Phase register, row latch and commit walker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            row_q <= '0;
            walk  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (open_cmd) begin
                        state <= ST_LOAD;
                        row_q <= wr_word_addr[ADDR_W-1:COL_W];
                    end
                end
                ST_LOAD: begin
                    if (open_cmd) begin
                        row_q <= wr_word_addr[ADDR_W-1:COL_W];
                    end else if (restart_evt) begin
                        state <= ST_IDLE;
                    end else if (stop_evt) begin
                        state <= commit_go ? ST_COMMIT : ST_IDLE;
                        walk  <= '0;
                    end
                end
                ST_COMMIT: begin
                    walk <= walk + 1'b1;
                    if (walk == LAST_COL) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (tmr_done) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Array write controls and busy flag.
    always_comb begin
        ram_we    = (state == ST_COMMIT) && mask[walk];
        ram_waddr = {row_q, walk};
        tmr_start = (state == ST_COMMIT) && (walk == LAST_COL);
        busy      = (state == ST_COMMIT) || (state == ST_WAIT);
    end

    ee_pgw_buffer #(.COL_W(COL_W), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_cmd  (open_cmd),
        .start_col (wr_word_addr[COL_W-1:0]),
        .take_byte (take_byte),
        .byte_in   (data_byte),
        .drop_all  (drop_all),
        .rd_col    (walk),
        .rd_byte   (stage_byte),
        .mask      (mask)
    );

    ee_pgw_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .running (tmr_run),
        .done    (tmr_done)
    );

    ee_pgw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (stage_byte),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // The timer must be idle whenever the controller is not waiting on it.
    always_comb begin
        if (rst_n && tmr_run && !(state == ST_WAIT))
            $display("ee_page_commit: timer running outside wait phase");
    end
endmodule

// File: rtl/ee_page_commit_chk.sv
// Property checker for ee_page_commit, attached with bind. It watches the
// ports and the array write controls.
module ee_page_commit_chk #(
    parameter int ROW_W = 7,
    parameter int COL_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   busy,
    input logic                   stop_evt,
    input logic                   restart_evt,
    input logic                   wr_cmd_vld,
    input logic                   wp_in,
    input logic                   in_load,
    input logic                   ram_we,
    input logic [ROW_W+COL_W-1:0] ram_waddr
);
    // R6: the array is written only inside a busy period.
    p_write_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> busy);

    // R7: STOP under write protect starts no programming.
    p_wp_no_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_load && stop_evt && wp_in) |=> !busy);

    // R8: a repeated START cancels the command.
    p_restart_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_load && restart_evt && !wr_cmd_vld) |=> !busy);

    // R5: busy only rises straight after a STOP during a command.
    p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_load && stop_evt));

    // R2: consecutive array writes stay in one row.
    p_row_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we)) |->
        (ram_waddr[ROW_W+COL_W-1:COL_W] == $past(ram_waddr[ROW_W+COL_W-1:COL_W])));

    // R10: reset leaves the controller not busy.
    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> !busy);
endmodule

bind ee_page_commit ee_page_commit_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .stop_evt    (stop_evt),
    .restart_evt (restart_evt),
    .wr_cmd_vld  (wr_cmd_vld),
    .wp_in       (wp_in),
    .in_load     (in_load),
    .ram_we      (ram_we),
    .ram_waddr   (ram_waddr)
);

// File: tb/ee_page_commit_test.sv
// Self-checking bench for ee_page_commit.
module ee_page_commit_test;
    localparam int ROW_W  = 7;
    localparam int COL_W  = 4;
    localparam int DATA_W = 8;
    localparam int PROG   = 40;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int BUSY_LEN = 16 + PROG;

    // Vector: {wp[25], count[24:19], word address[18:8], seed[7:0]}
    localparam int NVEC = 8;
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b0, 6'd16, 11'h000, 8'h10},  // R1 R2: full page 0 from column 0
        {1'b0, 6'd16, 11'h015, 8'h20},  // R2 R3: full page 1 from mid-page
        {1'b0, 6'd16, 11'h7F0, 8'h30},  // R1: full last page
        {1'b0, 6'd4,  11'h003, 8'h40},  // R4: partial write inside page 0
        {1'b0, 6'd5,  11'h01E, 8'h50},  // R3 R4: short run crossing page end
        {1'b0, 6'd20, 11'h7F8, 8'h60},  // R3: 20 bytes overlap themselves
        {1'b1, 6'd3,  11'h000, 8'h70},  // R7: protected write dropped
        {1'b0, 6'd0,  11'h7F0, 8'h00}   // R5: STOP with no data
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_cmd_vld = 1'b0;
    logic [ADDR_W-1:0] wr_word_addr = '0;
    logic data_vld = 1'b0;
    logic [DATA_W-1:0] data_byte = '0;
    logic stop_evt = 1'b0;
    logic restart_evt = 1'b0;
    logic wp_in = 1'b0;
    logic busy;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;

    logic [DATA_W-1:0] mdl [1 << ADDR_W];
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ee_page_commit #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                     .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .wr_cmd_vld(wr_cmd_vld),
        .wr_word_addr(wr_word_addr), .data_vld(data_vld), .data_byte(data_byte),
        .stop_evt(stop_evt), .restart_evt(restart_evt), .wp_in(wp_in),
        .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [ADDR_W-1:0] a);
        @(negedge clk) wr_cmd_vld = 1'b1; wr_word_addr = a;
        @(negedge clk) wr_cmd_vld = 1'b0;
    endtask

    task automatic send_byte(input logic [DATA_W-1:0] d);
        @(negedge clk) data_vld = 1'b1; data_byte = d;
        @(negedge clk) data_vld = 1'b0;
    endtask

    // Drive STOP and count the busy cycles that follow.
    task automatic stop_and_count(output int n);
        @(negedge clk) stop_evt = 1'b1;
        @(negedge clk) stop_evt = 1'b0;
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_byte(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk) rd_addr = a;
        @(negedge clk) d = rd_data;
    endtask

    task automatic check_page(input string req, input logic [ROW_W-1:0] row);
        logic [DATA_W-1:0] d;
        for (int c = 0; c < 16; c++) begin
            read_byte({row, COL_W'(c)}, d);
            chk(req, {24'h0, d}, {24'h0, mdl[{row, COL_W'(c)}]});
        end
    endtask

    // Watchdog: a hang counts as a failure and still reaches the summary.
    initial begin
        #1_500_000;
        failures++;
        $display("FAIL R6 watchdog actual=hang expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        logic [DATA_W-1:0] d;

        // R10: busy low during and after reset.
        repeat (3) @(negedge clk);
        chk("R10 busy in reset", {31'h0, busy}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 busy after reset", {31'h0, busy}, 32'h0);

        // Table walk.
        for (int v = 0; v < NVEC; v++) begin
            logic wp;
            logic [5:0] cnt;
            logic [ADDR_W-1:0] a;
            logic [7:0] seed;
            {wp, cnt, a, seed} = VEC[v];
            wp_in = wp;
            send_cmd(a);
            for (int i = 0; i < cnt; i++)
                send_byte(seed + 8'(i));
            stop_and_count(n);
            wp_in = 1'b0;
            if (!wp && cnt != 0) begin
                for (int i = 0; i < cnt; i++)
                    mdl[{a[ADDR_W-1:COL_W], COL_W'(a[COL_W-1:0] + COL_W'(i))}] = seed + 8'(i);
                chk("R6 busy length", n, BUSY_LEN);
            end else begin
                chk(wp ? "R7 no busy under protect" : "R5 no busy without data", n, 0);
            end
            check_page("R1 R2 R3 R4 page content", a[ADDR_W-1:COL_W]);
        end

        // R8: repeated START after address and bytes cancels.
        send_cmd(11'h010);
        send_byte(8'hC1);
        send_byte(8'hC2);
        @(negedge clk) restart_evt = 1'b1;
        @(negedge clk) restart_evt = 1'b0;
        stop_and_count(n);
        chk("R8 cancel no busy", n, 0);
        check_page("R8 page kept", 7'd1);

        // R11: a second command discards bytes of the first.
        send_cmd(11'h000);
        send_byte(8'hA1);
        send_byte(8'hA2);
        send_cmd(11'h008);
        send_byte(8'hB1);
        stop_and_count(n);
        mdl[11'h008] = 8'hB1;
        chk("R11 busy length", n, BUSY_LEN);
        check_page("R11 only second command committed", 7'd0);

        // R6: inputs during busy are ignored.
        send_cmd(11'h7F0);
        send_byte(8'hD0);
        @(negedge clk) stop_evt = 1'b1;
        @(negedge clk) stop_evt = 1'b0;
        mdl[11'h7F0] = 8'hD0;
        send_cmd(11'h000);
        send_byte(8'hEE);
        @(negedge clk) stop_evt = 1'b1;
        @(negedge clk) stop_evt = 1'b0;
        chk("R6 still busy", {31'h0, busy}, 32'h1);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        n = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (busy) n++;
        end
        chk("R6 no second cycle", n, 0);
        check_page("R6 page 0 untouched", 7'd0);
        check_page("R6 last page", 7'd127);

        // R7: protect raised between the bytes and STOP.
        send_cmd(11'h7F4);
        send_byte(8'h99);
        wp_in = 1'b1;
        stop_and_count(n);
        chk("R7 protect at STOP", n, 0);
        // R9: reads work while protected.
        read_byte(11'h7F4, d);
        chk("R9 read under protect", {24'h0, d}, {24'h0, mdl[11'h7F4]});
        wp_in = 1'b0;
        check_page("R7 last page kept", 7'd127);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule